// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is the timing heart of a system watchdog. Once armed, it counts down a first interval. When that interval runs out it raises a warning interrupt, either a normal interrupt request or a system-management interrupt. It then counts down a second, separately programmed interval. If software still has not serviced it when the second interval ends, the block issues a reboot request. At the same moment it strobes a flag that records that the watchdog caused the reboot.

Both intervals come from 20-bit preload values. The block scales them internally by a selectable power of two: a coarse shift for slow operation and a fine shift for fast operation. All counting advances on a shared base-tick enable. Software services the watchdog through a ping, which returns it to the start of the first interval. Register decoding and any unlock sequence sit outside this block and reach it as levels and one-cycle pulses. In free-running mode the block starts a new first interval after the second one expires.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the block is idle, reports the first stage (`in_stage2` low), and holds all pulse outputs low.
- R2: A stage lasts `max(1, preload << 5)` asserted ticks when `fast_scale` is 1, and `max(1, preload << 15)` ticks when it is 0. Cycles without `tick` do not advance the count.
- R3: An `enable_rise` pulse starts the first stage from `preload_a`, whatever state the block is in.
- R4: When the first stage expires, `irq_mode` selects the warning. 2'b00 gives an `irq_pulse`, 2'b10 gives an `smi_pulse`, and 2'b01 or 2'b11 give no warning. The pulse appears in the cycle after the expiring tick.
- R5: Right after the first stage expires, the second stage counts from `preload_b`, and `in_stage2` stays high for exactly that stage.
- R6: When the second stage expires with `reboot_en` high, `reboot_pulse` and `prev_reboot_set` are both high for the same single cycle. With `reboot_en` low, neither is raised.
- R7: After the second stage expires, `in_stage2` returns low. With `free_run` high the first stage restarts at once. With `free_run` low the block stops and raises no further pulses.
- R8: A `ping` while `enable` is high restarts the first stage from `preload_a`. A ping arriving on the tick that would expire the stage wins over the expiry.
- R9: A `ping` while `enable` is low has no effect on the countdown.
- R10: A `disable_pulse` stops counting, and it wins over an expiry on the same tick.
- R11: `irq_pulse`, `smi_pulse` and `reboot_pulse` are each one clock wide, and `irq_pulse` and `smi_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base tick enable |
| preload_a | input | 20 | First-stage preload |
| preload_b | input | 20 | Second-stage preload |
| fast_scale | input | 1 | 1: shift preloads by 5, 0: by 15 |
| irq_mode | input | 2 | 00 IRQ, 10 SMI, 01/11 none |
| reboot_en | input | 1 | Allow reboot on second-stage expiry |
| free_run | input | 1 | Restart first stage after second-stage expiry |
| enable | input | 1 | Watchdog enabled level (gates ping) |
| enable_rise | input | 1 | Pulse: enable went 0 to 1 |
| disable_pulse | input | 1 | Pulse: stop counting |
| ping | input | 1 | Pulse: service the watchdog |
| irq_pulse | output | 1 | First-stage interrupt request |
| smi_pulse | output | 1 | First-stage system-management interrupt |
| reboot_pulse | output | 1 | Second-stage reboot request |
| in_stage2 | output | 1 | 1 while the second stage is current |
| prev_reboot_set | output | 1 | Set strobe for the previous-reboot flag |

## Verification
The key collisions are an expiring tick that falls in the same cycle as a ping, as a disable pulse, or as a ping while `enable` is low. The bench counts asserted ticks from the start of the countdown and raises the colliding pulse on exactly the tick that would expire the first stage. It then judges the result by when the warning appears. After a valid ping, the warning must arrive exactly one full interval later. After a disable, no warning may appear. After a ping with `enable` low, the warning must appear on schedule.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PRE_W-1:0] preload_a,
  input  logic [PRE_W-1:0] preload_b,
  input  logic             fast_scale,
  input  logic [1:0]       irq_mode,
  input  logic             reboot_en,
  input  logic             free_run,
  input  logic             enable,
  input  logic             enable_rise,
  input  logic             disable_pulse,
  input  logic             ping,
  output logic             irq_pulse,
  output logic             smi_pulse,
  output logic             reboot_pulse,
  output logic             in_stage2,
  output logic             prev_reboot_set
);
  localparam int CNT_W = PRE_W + SLOW_SH;
  localparam logic [1:0] MODE_IRQ = 2'b00;
  localparam logic [1:0] MODE_SMI = 2'b10;

  logic             running;
  logic [CNT_W-1:0] cnt;

  wire [CNT_W-1:0] load_a = fast_scale ? (CNT_W'(preload_a) << FAST_SH)
                                       : (CNT_W'(preload_a) << SLOW_SH);
  wire [CNT_W-1:0] load_b = fast_scale ? (CNT_W'(preload_b) << FAST_SH)
                                       : (CNT_W'(preload_b) << SLOW_SH);
  wire restart = enable_rise | (ping & enable);
  wire expire  = running & tick & (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running         <= 1'b0;
      in_stage2       <= 1'b0;
      cnt             <= '0;
      irq_pulse       <= 1'b0;
      smi_pulse       <= 1'b0;
      reboot_pulse    <= 1'b0;
      prev_reboot_set <= 1'b0;
    end else begin
      irq_pulse       <= 1'b0;
      smi_pulse       <= 1'b0;
      reboot_pulse    <= 1'b0;
      prev_reboot_set <= 1'b0;
      if (disable_pulse) begin
        running <= 1'b0;
      end else if (restart) begin
        running   <= 1'b1;
        in_stage2 <= 1'b0;
        cnt       <= load_a;
      end else if (expire) begin
        if (!in_stage2) begin
          irq_pulse <= (irq_mode == MODE_IRQ);
          smi_pulse <= (irq_mode == MODE_SMI);
          in_stage2 <= 1'b1;
          cnt       <= load_b;
        end else begin
          reboot_pulse    <= reboot_en;
          prev_reboot_set <= reboot_en;
          in_stage2       <= 1'b0;
          running         <= free_run;
          cnt             <= load_a;
        end
      end else if (running && tick) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic reboot_en,
  input logic disable_pulse,
  input logic irq_pulse,
  input logic smi_pulse,
  input logic reboot_pulse,
  input logic in_stage2,
  input logic prev_reboot_set
);
  // R11
  irq_smi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && smi_pulse));

  // R11
  irq_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R11
  reboot_one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_pulse |=> !reboot_pulse);

  // R5
  warn_enters_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || smi_pulse) |-> in_stage2);

  // R6
  reboot_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_pulse |-> ($past(reboot_en) && prev_reboot_set && !in_stage2));

  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disable_pulse) |-> !(irq_pulse || smi_pulse || reboot_pulse));

  // R2
  stage_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stage2) |-> $past(tick));
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reboot_en(reboot_en),
  .disable_pulse(disable_pulse), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
  .reboot_pulse(reboot_pulse), .in_stage2(in_stage2),
  .prev_reboot_set(prev_reboot_set)
);

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [19:0] preload_a = '0, preload_b = '0;
  logic fast_scale = 1'b1;
  logic [1:0] irq_mode = 2'b00;
  logic reboot_en = 1'b0, free_run = 1'b0, enable = 1'b0;
  logic enable_rise = 1'b0, disable_pulse = 1'b0, ping = 1'b0;
  logic irq_pulse, smi_pulse, reboot_pulse, in_stage2, prev_reboot_set;

  int total = 0, bad = 0;
  int tk, irq_n, smi_n, rb_n, irq_first, irq_last, smi_first, rb_first, prs_first;

  always #5 clk = ~clk;

  wdt_two_stage i_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preload_a(preload_a),
    .preload_b(preload_b), .fast_scale(fast_scale), .irq_mode(irq_mode),
    .reboot_en(reboot_en), .free_run(free_run), .enable(enable),
    .enable_rise(enable_rise), .disable_pulse(disable_pulse), .ping(ping),
    .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reboot_pulse(reboot_pulse),
    .in_stage2(in_stage2), .prev_reboot_set(prev_reboot_set)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    tk = 0; irq_n = 0; smi_n = 0; rb_n = 0;
    irq_first = -1; irq_last = -1; smi_first = -1; rb_first = -1; prs_first = -1;
  endtask

  task automatic step(input bit t, input bit p, input bit d);
    tick = t; ping = p; disable_pulse = d;
    @(negedge clk);
    tick = 1'b0; ping = 1'b0; disable_pulse = 1'b0;
    if (t) tk++;
    if (irq_pulse) begin irq_n++; irq_last = tk; if (irq_first < 0) irq_first = tk; end
    if (smi_pulse) begin smi_n++; if (smi_first < 0) smi_first = tk; end
    if (reboot_pulse) begin rb_n++; if (rb_first < 0) rb_first = tk; end
    if (prev_reboot_set && prs_first < 0) prs_first = tk;
  endtask

  task automatic stop_wdt();
    enable = 1'b0; disable_pulse = 1'b1;
    @(negedge clk);
    disable_pulse = 1'b0;
  endtask

  task automatic start_wdt();
    enable = 1'b1; enable_rise = 1'b1;
    @(negedge clk);
    enable_rise = 1'b0;
    clear_rec();
  endtask

  function automatic int stage_len(input int pre, input bit fast);
    int v;
    v = fast ? (pre << 5) : (pre << 15);
    return (v < 1) ? 1 : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int na, nb, cyc, smis, endtk;
    repeat (3) @(negedge clk);
    chk("R1 irq after reset", int'(irq_pulse), 0);
    chk("R1 stage after reset", int'(in_stage2), 0);
    chk("R1 reboot after reset", int'(reboot_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_rec();
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b0);
    chk("R1 idle after reset, no pulses", irq_n + rb_n, 0);

    // sweep: R2 R3 R4 R5 R6 R7 R11
    fast_scale = 1'b1; free_run = 1'b0;
    for (int pa = 0; pa < 4; pa++)
      for (int pb = 0; pb < 3; pb++)
        for (int md = 0; md < 4; md++) begin
          stop_wdt();
          preload_a = 20'(pa); preload_b = 20'(pb);
          irq_mode = 2'(md); reboot_en = ((pa + md) % 2) == 1;
          na = stage_len(pa, 1'b1); nb = stage_len(pb, 1'b1);
          start_wdt();
          cyc = 0; smis = 0; endtk = na + nb + 3;
          while (tk < endtk) begin
            step((cyc % ((pb % 2) + 1)) == 0, 1'b0, 1'b0);
            cyc++;
            if (int'(in_stage2) != int'(tk >= na && tk < na + nb)) smis++;
          end
          chk("R4 irq tick", irq_first, (md == 0) ? na : -1);
          chk("R4 smi tick", smi_first, (md == 2) ? na : -1);
          chk("R11 warn count", irq_n + smi_n, (md == 0 || md == 2) ? 1 : 0);
          chk("R6 reboot tick", rb_first, reboot_en ? na + nb : -1);
          chk("R6 prev_reboot_set tick", prs_first, reboot_en ? na + nb : -1);
          chk("R7 no restart without free_run", rb_n, reboot_en ? 1 : 0);
          chk("R5 stage indicator mismatches", smis, 0);
        end

    // R7 free-run restart
    stop_wdt();
    preload_a = 20'd1; preload_b = 20'd2; irq_mode = 2'b00;
    reboot_en = 1'b1; free_run = 1'b1;
    na = 32; nb = 64;
    start_wdt();
    while (tk < 2 * na + nb + 2) step(1'b1, 1'b0, 1'b0);
    chk("R7 free_run second irq count", irq_n, 2);
    chk("R7 free_run second irq tick", irq_last, 2 * na + nb);
    chk("R6 free_run reboot tick", rb_first, na + nb);
    free_run = 1'b0;

    // R2 slow scale
    stop_wdt();
    fast_scale = 1'b0; preload_a = 20'd1; preload_b = 20'd0;
    irq_mode = 2'b10; reboot_en = 1'b0;
    na = 32768; nb = 1;
    start_wdt();
    while (tk < na + nb + 3) step(1'b1, 1'b0, 1'b0);
    chk("R2 slow scale smi tick", smi_first, na);
    chk("R2 slow scale no irq", irq_n, 0);
    chk("R6 no reboot when disabled", rb_n, 0);
    fast_scale = 1'b1;

    // R8 ping on the expiring tick
    stop_wdt();
    preload_a = 20'd2; preload_b = 20'd1; irq_mode = 2'b00; reboot_en = 1'b1;
    na = 64;
    start_wdt();
    while (tk < na - 1) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R8 ping beats expiry", irq_n, 0);
    while (tk < 2 * na + 2) step(1'b1, 1'b0, 1'b0);
    chk("R8 irq one interval after ping", irq_first, 2 * na);

    // R8 ping in stage 2 returns to stage 1
    stop_wdt();
    start_wdt();
    while (tk < na + 5) step(1'b1, 1'b0, 1'b0);
    chk("R5 in stage 2 before ping", int'(in_stage2), 1);
    step(1'b0, 1'b1, 1'b0);
    chk("R8 ping clears stage 2", int'(in_stage2), 0);
    while (tk < 2 * na + 8) step(1'b1, 1'b0, 1'b0);
    chk("R8 no reboot after stage-2 ping", rb_n, 0);

    // R9 ping with enable low
    stop_wdt();
    start_wdt();
    while (tk < na - 1) step(1'b1, 1'b0, 1'b0);
    enable = 1'b0;
    step(1'b1, 1'b1, 1'b0);
    chk("R9 ignored ping, irq on schedule", irq_first, na);
    enable = 1'b1;

    // R10 disable on the expiring tick
    stop_wdt();
    start_wdt();
    while (tk < na - 1) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    while (tk < 3 * na) step(1'b1, 1'b0, 1'b0);
    chk("R10 disable suppresses irq", irq_n, 0);
    chk("R10 disable suppresses reboot", rb_n, 0);
    chk("R10 stage stays 1", int'(in_stage2), 0);

    // R3 re-arm mid-count restarts from preload_a
    stop_wdt();
    start_wdt();
    while (tk < 20) step(1'b1, 1'b0, 1'b0);
    start_wdt();
    while (tk < na + 2) step(1'b1, 1'b0, 1'b0);
    chk("R3 enable_rise restart", irq_first, na);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule